// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block sits on the host side of a three-wire serial EEPROM and runs one command at a time. A command arrives as an operation code, an address and write data, and it is accepted with a valid/ready handshake. The block then raises chip select and generates a divided serial clock. It shifts out a start bit, the opcode, the address field and any write data, and it samples the device's data line to collect read data. When the command is finished it pulses `done_o`, with the read word and an error flag alongside.

The EEPROM organization is fixed by a parameter. Byte organization uses a 9-bit address field and 8-bit data. Word organization uses an 8-bit address field and 16-bit data. Chip select always stays low for at least a programmable number of system cycles between two selections. A program command (erase, erase all, write, write all) leaves the device busy. After such a command the block drops chip select, waits out the gap, selects the device again and watches the data line until it reads high. A limit counter ends this wait with an error if the device never reports ready.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: Each frame is sent MSB first: a 1 start bit, then a 2-bit opcode, then the address field, then the data field where the command carries data. `eep_di_o` changes only while `eep_sclk_o` is low.
- R2: The number of rising serial-clock edges in a frame is 3 plus the address field width, plus the data width for read, write and write all. With byte organization this gives 12, or 20 for those three commands.
- R3: The `cmd_op` encodings that put opcode 00 on the line are 3 (erase all), 4 (write all), 5 (write enable), 6 (write disable) and 7 (treated as write disable). For these, the two upper address-field bits carry 10, 01, 11, 00 and 00 respectively, and every lower address-field bit is sent as 0.
- R4: `cmd_op` 0 (read) sends opcode 10, 1 (write) sends 01 and 2 (erase) sends 11. Each sends a 0 in the top address-field bit, followed by `cmd_addr`.
- R5: While the frame is shifted, each high phase and each low phase of `eep_sclk_o` lasts exactly HALF_DIV system cycles. `eep_sclk_o` is low whenever `eep_cs_o` is low.
- R6: Between any two selections, including the reselect used for polling, `eep_cs_o` stays low for at least GAP_CYCLES system cycles.
- R7: After erase, erase all, write or write all, chip select is raised a second time with no serial-clock edges. `done_o` comes only after `eep_do_i` has read 1 and the gap has passed again. The other commands select the device exactly once.
- R8: If `eep_do_i` stays 0 for POLL_LIMIT cycles of polling, `err_o` is 1 when `done_o` pulses. `err_o` is cleared when the next command is accepted.
- R9: For a read, the bits on `eep_do_i` at the rising serial-clock edges after the address field form `rd_data_o`, MSB first. The value is valid when `done_o` pulses.
- R10: `cmd_ready` is high only while the block is idle, and a command is taken only when `cmd_valid` and `cmd_ready` are both high. `done_o` is a one-cycle pulse. A `cmd_valid` held high through a command starts no second command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Controller idle, can take a command |
| cmd_op | input | 3 | Operation code (see R3, R4) |
| cmd_addr | input | AW (8 byte / 7 word) | Memory address |
| cmd_wdata | input | DW (8 byte / 16 word) | Write data for write and write all |
| done_o | output | 1 | One-cycle end-of-command pulse |
| rd_data_o | output | DW | Read data, valid with done_o |
| err_o | output | 1 | Busy polling timed out |
| eep_cs_o | output | 1 | Chip select to the EEPROM |
| eep_sclk_o | output | 1 | Serial clock to the EEPROM |
| eep_di_o | output | 1 | Serial data to the EEPROM |
| eep_do_i | input | 1 | Serial data / ready level from the EEPROM |

## Verification
The hardest case to reach from the ports is the polling timeout. A normal device always finishes its program cycle, so the expiry branch is never exercised. The bench's device model therefore has a stuck-busy switch that holds the data line low for a whole write. The bench then checks that the error flag arrives with `done_o`, that the device was reselected, and that the next read comes back with the flag cleared. A second hard-to-reach case is a request that stays valid through a whole command. The driver holds `cmd_valid` until `done_o`, and the scoreboard would flag any extra frame as one that has no expected entry.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    MW_READ       = 3'd0,
    MW_WRITE      = 3'd1,
    MW_ERASE      = 3'd2,
    MW_ERASE_ALL  = 3'd3,
    MW_WRITE_ALL  = 3'd4,
    MW_WR_ENABLE  = 3'd5,
    MW_WR_DISABLE = 3'd6
  } mw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_POLL  = 2'd3
  } mw_state_e;

endpackage

// File: rtl/mw_halfbit_div.sv
module mw_halfbit_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);

  // each half phase needs a fresh count while running
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && run && (HALF_DIV > 1)) |=> !tick);

endmodule

// File: rtl/mw_interval.sv
module mw_interval #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          running_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (start) begin
      cnt_q     <= LOAD;
      running_q <= 1'b1;
    end else if (running_q) begin
      if (cnt_q == '0) begin
        running_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign expired = running_q && (cnt_q == '0);

  assert_interval_once_R6: assert property (@(posedge clk) disable iff (rst)
    (expired && !start) |=> !expired);

endmodule

// File: rtl/mw_framer.sv
module mw_framer
  import mw_pkg::*;
#(
  parameter int AFW = 9,
  parameter int DW  = 8,
  parameter int FL  = 3 + AFW + DW,
  parameter int LW  = $clog2(FL + 1)
) (
  input  logic [2:0]     op_i,
  input  logic [AFW-2:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [FL-1:0]  frame_o,
  output logic [LW-1:0]  len_o,
  output logic           poll_o
);
  localparam int HDR = 3 + AFW;

  logic [1:0]     opc;
  logic [AFW-1:0] fld;
  logic [DW-1:0]  dat;
  logic           has_data;

  always_comb begin
    opc      = 2'b00;
    fld      = '0;
    dat      = '0;
    has_data = 1'b0;
    poll_o   = 1'b0;
    case (mw_op_e'(op_i))
      MW_READ: begin
        opc      = 2'b10;
        fld      = {1'b0, addr_i};
        has_data = 1'b1;
      end
      MW_WRITE: begin
        opc      = 2'b01;
        fld      = {1'b0, addr_i};
        dat      = wdata_i;
        has_data = 1'b1;
        poll_o   = 1'b1;
      end
      MW_ERASE: begin
        opc    = 2'b11;
        fld    = {1'b0, addr_i};
        poll_o = 1'b1;
      end
      MW_ERASE_ALL: begin
        fld[AFW-1 -: 2] = 2'b10;
        poll_o          = 1'b1;
      end
      MW_WRITE_ALL: begin
        fld[AFW-1 -: 2] = 2'b01;
        dat             = wdata_i;
        has_data        = 1'b1;
        poll_o          = 1'b1;
      end
      MW_WR_ENABLE: begin
        fld[AFW-1 -: 2] = 2'b11;
      end
      default: begin
        fld[AFW-1 -: 2] = 2'b00;
      end
    endcase
  end

  assign frame_o = {1'b1, opc, fld, dat};
  assign len_o   = LW'(HDR) + (has_data ? LW'(DW) : LW'(0));

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int WORD_ORG   = 0,
  parameter int HALF_DIV   = 4,
  parameter int GAP_CYCLES = 25,
  parameter int POLL_LIMIT = 100000,
  localparam int AFW = (WORD_ORG != 0) ? 8 : 9,
  localparam int AW  = AFW - 1,
  localparam int DW  = (WORD_ORG != 0) ? 16 : 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          err_o,
  output logic          eep_cs_o,
  output logic          eep_sclk_o,
  output logic          eep_di_o,
  input  logic          eep_do_i
);
  localparam int HDR = 3 + AFW;
  localparam int FL  = HDR + DW;
  localparam int LW  = $clog2(FL + 1);
  localparam int GW  = $clog2(GAP_CYCLES + 1);

  mw_state_e     state_q;
  logic [FL-1:0] frame_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] bit_q;
  logic          poll_q;
  logic          cs_q, sclk_q, di_q;
  logic [DW-1:0] rd_q;
  logic          done_q, err_q;

  logic [FL-1:0] fr_frame;
  logic [LW-1:0] fr_len;
  logic          fr_poll;
  logic          tick;
  logic          gap_exp, poll_exp;
  logic          shift_end, poll_end, gap_start, poll_start;

  mw_framer #(.AFW(AFW), .DW(DW), .FL(FL), .LW(LW)) framer_i (
    .op_i    (cmd_op),
    .addr_i  (cmd_addr),
    .wdata_i (cmd_wdata),
    .frame_o (fr_frame),
    .len_o   (fr_len),
    .poll_o  (fr_poll)
  );

  mw_halfbit_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_SHIFT),
    .tick (tick)
  );

  mw_interval #(.CYCLES(GAP_CYCLES)) gap_i (
    .clk     (clk),
    .rst     (rst),
    .start   (gap_start),
    .expired (gap_exp)
  );

  mw_interval #(.CYCLES(POLL_LIMIT)) poll_i (
    .clk     (clk),
    .rst     (rst),
    .start   (poll_start),
    .expired (poll_exp)
  );

  assign shift_end  = (state_q == ST_SHIFT) && tick && sclk_q &&
                      (bit_q == len_q - LW'(1));
  assign poll_end   = (state_q == ST_POLL) && (eep_do_i || poll_exp);
  assign gap_start  = shift_end || poll_end;
  assign poll_start = (state_q == ST_GAP) && gap_exp && poll_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      len_q   <= '0;
      bit_q   <= '0;
      poll_q  <= 1'b0;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      di_q    <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            frame_q <= fr_frame;
            len_q   <= fr_len;
            poll_q  <= fr_poll;
            bit_q   <= '0;
            cs_q    <= 1'b1;
            sclk_q  <= 1'b0;
            di_q    <= fr_frame[FL-1];
            err_q   <= 1'b0;
            rd_q    <= '0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              if (bit_q >= LW'(HDR)) begin
                rd_q <= {rd_q[DW-2:0], eep_do_i};
              end
            end else begin
              sclk_q <= 1'b0;
              if (shift_end) begin
                cs_q    <= 1'b0;
                di_q    <= 1'b0;
                state_q <= ST_GAP;
              end else begin
                bit_q   <= bit_q + LW'(1);
                frame_q <= frame_q << 1;
                di_q    <= frame_q[FL-2];
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_exp) begin
            if (poll_q) begin
              cs_q    <= 1'b1;
              state_q <= ST_POLL;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_POLL: begin
          if (poll_end) begin
            if (!eep_do_i) begin
              err_q <= 1'b1;
            end
            cs_q    <= 1'b0;
            poll_q  <= 1'b0;
            state_q <= ST_GAP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state_q == ST_IDLE);
  assign done_o     = done_q;
  assign rd_data_o  = rd_q;
  assign err_o      = err_q;
  assign eep_cs_o   = cs_q;
  assign eep_sclk_o = sclk_q;
  assign eep_di_o   = di_q;

  // checker state: cycles since chip select fell, edges in the current selection
  logic [GW-1:0] cs_low_cnt;
  logic [LW-1:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_low_cnt <= GW'(GAP_CYCLES);
      rise_cnt   <= '0;
    end else begin
      if (cs_q) begin
        cs_low_cnt <= '0;
      end else if (cs_low_cnt < GW'(GAP_CYCLES)) begin
        cs_low_cnt <= cs_low_cnt + GW'(1);
      end
      if (!cs_q) begin
        rise_cnt <= '0;
      end else if (tick && !sclk_q && (state_q == ST_SHIFT)) begin
        rise_cnt <= rise_cnt + LW'(1);
      end
    end
  end

  assert_di_hold_R1: assert property (@(posedge clk) disable iff (rst)
    eep_sclk_o |-> $stable(eep_di_o));

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(eep_cs_o) |-> ((rise_cnt == len_q) || (rise_cnt == '0)));

  assert_sclk_parked_R5: assert property (@(posedge clk) disable iff (rst)
    !eep_cs_o |-> !eep_sclk_o);

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(eep_cs_o) |-> (cs_low_cnt >= GW'(GAP_CYCLES)));

  assert_poll_no_clock_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POLL) |-> !eep_sclk_o);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (eep_cs_o && !cmd_ready));

endmodule

// File: tb/mw_eeprom_ctrl_tb_top.sv
module mw_eeprom_ctrl_tb_top;
  localparam int HALF   = 3;
  localparam int GAP    = 7;
  localparam int PLIM   = 300;
  localparam int BUSY   = 50;
  localparam int AFW    = 9;
  localparam int AW     = 8;
  localparam int DW     = 8;
  localparam int HDR    = 3 + AFW;
  localparam int FL     = HDR + DW;
  localparam int NWORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          done_o, err_o;
  logic [DW-1:0] rd_data_o;
  logic          eep_cs, eep_sclk, eep_di, eep_do;

  mw_eeprom_ctrl #(.WORD_ORG(0), .HALF_DIV(HALF), .GAP_CYCLES(GAP), .POLL_LIMIT(PLIM)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .done_o     (done_o),
    .rd_data_o  (rd_data_o),
    .err_o      (err_o),
    .eep_cs_o   (eep_cs),
    .eep_sclk_o (eep_sclk),
    .eep_di_o   (eep_di),
    .eep_do_i   (eep_do)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [FL-1:0] q_frame[$];
  int            q_len[$];
  logic [DW-1:0] q_rd[$];
  bit            q_isrd[$];
  bit            q_err[$];
  bit            q_poll[$];
  int            q_rise0[$];

  logic [DW-1:0] ref_mem [NWORDS];

  // ---------------- device model ----------------
  logic [DW-1:0] mem [NWORDS];
  logic [FL-1:0] rx_sh;
  int            rx_n;
  logic [DW-1:0] rd_sh;
  bit            rd_ph;
  int            busy_cnt;
  bit            stuck = 1'b0;
  int            total_rises;
  logic          cs_prev, sclk_prev, di_prev;
  int            run_s, low_run;
  int            di_viol, hp_viol, gap_viol;

  assign eep_do = eep_cs && (rd_ph ? rd_sh[DW-1] : !((busy_cnt > 0) || stuck));

  task automatic frame_end();
    logic [FL-1:0]  f;
    logic [1:0]     oc;
    logic [AFW-1:0] fl;
    logic [DW-1:0]  d;
    f  = rx_sh << (FL - rx_n);
    oc = f[FL-2 -: 2];
    fl = f[FL-4 -: AFW];
    d  = f[FL-4-AFW -: DW];
    if (q_frame.size() == 0) begin
      check(1'b0, "R10 unexpected frame", 32'(rx_n), 32'd0);
    end else begin
      logic [FL-1:0] ef;
      int            en;
      ef = q_frame.pop_front();
      en = q_len.pop_front();
      check(rx_n == en, "R2 clock count", 32'(rx_n), 32'(en));
      check(f == ef, "R1 R3 R4 frame bits", 32'(f), 32'(ef));
    end
    case (oc)
      2'b01: begin mem[fl[AW-1:0]] = d; busy_cnt = BUSY; end
      2'b11: begin mem[fl[AW-1:0]] = '1; busy_cnt = BUSY; end
      2'b00: begin
        if (fl[AFW-1 -: 2] == 2'b10) begin
          for (int i = 0; i < NWORDS; i++) mem[i] = '1;
          busy_cnt = BUSY;
        end else if (fl[AFW-1 -: 2] == 2'b01) begin
          for (int i = 0; i < NWORDS; i++) mem[i] = d;
          busy_cnt = BUSY;
        end
      end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) mem[i] = DW'(i * 7 + 3);
      rx_sh = '0; rx_n = 0; rd_sh = '0; rd_ph = 1'b0; busy_cnt = 0;
      total_rises = 0; cs_prev = 1'b0; sclk_prev = 1'b0; di_prev = 1'b0;
      run_s = 0; low_run = GAP; di_viol = 0; hp_viol = 0; gap_viol = 0;
    end else begin
      if (busy_cnt > 0) busy_cnt--;
      // R5: phase lengths and parked clock
      if (!eep_cs && eep_sclk) hp_viol++;
      if (eep_sclk != sclk_prev) begin
        if (sclk_prev && run_s != HALF) hp_viol++;
        if (!sclk_prev && rx_n > 0 && run_s != HALF) hp_viol++;
        run_s = 1;
      end else begin
        run_s++;
      end
      // R1: data line steady while clock high
      if (eep_sclk && (eep_di != di_prev)) di_viol++;
      // R6: chip-select low time
      if (eep_cs && !cs_prev) begin
        if (low_run < GAP) gap_viol++;
        total_rises++;
        rx_n = 0; rx_sh = '0; rd_ph = 1'b0;
      end
      if (!eep_cs) low_run++; else low_run = 0;
      if (eep_cs && eep_sclk && !sclk_prev) begin
        rx_sh = {rx_sh[FL-2:0], eep_di};
        rx_n++;
        if (rd_ph) rd_sh = rd_sh << 1;
        if (rx_n == HDR && rx_sh[HDR-1] && rx_sh[AFW+1:AFW] == 2'b10) begin
          rd_ph = 1'b1;
          rd_sh = mem[rx_sh[AW-1:0]];
        end
      end
      if (!eep_cs && cs_prev && rx_n > 0) begin
        frame_end();
        rx_n  = 0;
        rd_ph = 1'b0;
      end
      cs_prev = eep_cs; sclk_prev = eep_sclk; di_prev = eep_di;
    end
  end

  // ---------------- result monitor ----------------
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (q_rd.size() == 0) begin
        check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [DW-1:0] er;
        bit            ir, ee, pp;
        int            r0;
        er = q_rd.pop_front(); ir = q_isrd.pop_front(); ee = q_err.pop_front();
        pp = q_poll.pop_front(); r0 = q_rise0.pop_front();
        if (ir) check(rd_data_o == er, "R9 read data", 32'(rd_data_o), 32'(er));
        check(err_o == ee, "R8 error flag", 32'(err_o), 32'(ee));
        check((total_rises - r0) == (pp ? 2 : 1), "R7 selections",
              32'(total_rises - r0), pp ? 32'd2 : 32'd1);
        if (pp && !ee) check(busy_cnt == 0, "R7 done before ready", 32'(busy_cnt), 32'd0);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic build(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [FL-1:0] f, output int n, output bit poll);
    logic [1:0]     oc;
    logic [AFW-1:0] fl;
    logic [DW-1:0]  dd;
    bit             hd;
    oc = 2'b00; fl = '0; dd = '0; hd = 1'b0; poll = 1'b0;
    case (op)
      3'd0: begin oc = 2'b10; fl = {1'b0, a}; hd = 1'b1; end
      3'd1: begin oc = 2'b01; fl = {1'b0, a}; dd = d; hd = 1'b1; poll = 1'b1; end
      3'd2: begin oc = 2'b11; fl = {1'b0, a}; poll = 1'b1; end
      3'd3: begin fl[AFW-1 -: 2] = 2'b10; poll = 1'b1; end
      3'd4: begin fl[AFW-1 -: 2] = 2'b01; dd = d; hd = 1'b1; poll = 1'b1; end
      3'd5: fl[AFW-1 -: 2] = 2'b11;
      default: fl[AFW-1 -: 2] = 2'b00;
    endcase
    f = {1'b1, oc, fl, dd};
    n = HDR + (hd ? DW : 0);
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit exp_err, input bit hold);
    logic [FL-1:0] f;
    int            n;
    bit            poll;
    build(op, a, d, f, n, poll);
    q_frame.push_back(f);
    q_len.push_back(n);
    q_isrd.push_back(op == 3'd0);
    q_rd.push_back(ref_mem[a]);
    q_err.push_back(exp_err);
    q_poll.push_back(poll);
    q_rise0.push_back(total_rises);
    case (op)
      3'd1: ref_mem[a] = d;
      3'd2: ref_mem[a] = '1;
      3'd3: for (int i = 0; i < NWORDS; i++) ref_mem[i] = '1;
      3'd4: for (int i = 0; i < NWORDS; i++) ref_mem[i] = d;
      default: ;
    endcase
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    check(!cmd_ready && eep_cs, "R10 ready drops on accept", 32'(cmd_ready), 32'd0);
    if (!hold) cmd_valid = 1'b0;
    do @(negedge clk); while (!done_o);
    cmd_valid = 1'b0;
    @(negedge clk);
    check(!done_o, "R10 done one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) ref_mem[i] = DW'(i * 7 + 3);
    fork
      begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!eep_cs && !eep_sclk, "R5 reset lines low", {eep_cs, eep_sclk}, 32'd0);
        check(cmd_ready && !done_o, "R10 reset ready", {cmd_ready, done_o}, 32'd2);
        issue(3'd5, 8'h00, 8'h00, 1'b0, 1'b0);   // R3 enable
        issue(3'd1, 8'h15, 8'hA5, 1'b0, 1'b0);   // R4 R7 write
        issue(3'd0, 8'h15, 8'h00, 1'b0, 1'b0);   // R9 read
        issue(3'd0, 8'hE2, 8'h00, 1'b0, 1'b0);   // R9 untouched word
        issue(3'd2, 8'h15, 8'h00, 1'b0, 1'b0);   // R4 erase
        issue(3'd0, 8'h15, 8'h00, 1'b0, 1'b0);
        issue(3'd4, 8'h00, 8'h3C, 1'b0, 1'b0);   // R3 write all
        issue(3'd0, 8'h80, 8'h00, 1'b0, 1'b0);
        issue(3'd3, 8'h00, 8'h00, 1'b0, 1'b0);   // R3 erase all
        issue(3'd0, 8'h07, 8'h00, 1'b0, 1'b0);
        issue(3'd1, 8'hFF, 8'h5A, 1'b0, 1'b1);   // R10 valid held
        issue(3'd0, 8'hFF, 8'h00, 1'b0, 1'b1);
        issue(3'd6, 8'h00, 8'h00, 1'b0, 1'b0);   // R3 disable
        issue(3'd7, 8'h00, 8'h00, 1'b0, 1'b0);   // R3 code 7
        stuck = 1'b1;
        issue(3'd1, 8'h40, 8'hC3, 1'b1, 1'b0);   // R8 timeout
        stuck = 1'b0;
        repeat (BUSY + 2) @(negedge clk);
        issue(3'd0, 8'h40, 8'h00, 1'b0, 1'b0);   // R8 flag cleared
        check(di_viol == 0, "R1 data moved while clock high", 32'(di_viol), 32'd0);
        check(hp_viol == 0, "R5 clock phase length", 32'(hp_viol), 32'd0);
        check(gap_viol == 0, "R6 chip select gap", 32'(gap_viol), 32'd0);
        check(q_frame.size() == 0 && q_rd.size() == 0, "R10 scoreboard drained",
              32'(q_frame.size() + q_rd.size()), 32'd0);
      end
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R10 watchdog", 32'd0, 32'd1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule